// File: doc/BRIEF.md
# Oscillator and Phase Detector Register Slave

This block is an AHB slave that gives a processor memory-mapped control of a digitally controlled oscillator and of the phase error detector in a software-driven phase-locked loop. During the address phase it samples the select, address, direction and transfer type. In the data phase that follows, it either stores the write data or returns read data. It never inserts wait states and never signals an error. The stored control values go straight to the oscillator and detector ports.

Software writes four things: a 32-bit oscillator control word, an oscillator mode bit (frequency search or phase tracking), a feedback divide value for the detector, and a detector mode bit. It reads back one status word. That word holds the last signed error value from the time-to-digital converter together with a lead/lag flag. The status word is captured on the detector's valid strobe. The slave decodes only address bits 7:2 as a word index. Matching the peripheral window, whose base is 0x95000000, is left to the system decoder through the select input.

Top module: `dco_ahb_regif`

## Requirements
- R1: While hresetn is low, every control register is zero: oscillator coarse and fine fields, divide value, and both mode bits, which select frequency search. The status word is also zero.
- R2: A transfer is accepted only when hsel=1, hreadyin=1 and htrans is NONSEQ (2'b10) or SEQ (2'b11). An accepted write stores hwdata from the data-phase cycle that immediately follows the address phase.
- R3: A transfer with htrans IDLE (2'b00) or BUSY (2'b01), or with hsel=0, or with hreadyin=0, changes no register and gets an OKAY response.
- R4: Offset 0x14 holds the full 32-bit control word and reads it back unchanged. dco_coarse is bits 27:19 of that word, so writing 0x8ff80000 gives dco_coarse=0x1ff.
- R5: dco_fine is the remaining bits of the control word: {word[31:28], word[18:0]}, 23 bits.
- R6: Offset 0x10 bit 0 is the oscillator mode, where 1 means phase tracking and 0 means frequency search. It drives dco_track and reads back as {31'b0, bit}.
- R7: Offset 0x00 holds the divide value in bits DIV_W-1:0. It drives det_div and reads back zero-extended. Offset 0x04 bit 0 is the detector mode, which drives det_track.
- R8: Offset 0x08 reads the status word: det_lead in bit 31, zeros in bits 30:16 and det_err in bits 15:0. It is loaded at each clock edge where det_valid=1 and held otherwise.
- R9: Writes to 0x08 and to unmapped offsets (for example 0x0C, 0x18, 0x3C) change nothing. A read of an unmapped offset returns zero.
- R10: hreadyout is always 1 and hresp is always OKAY (2'b00). Read data appears in the data-phase cycle right after the address phase. In a data phase with no accepted read, hrdata is zero.
- R11: A write followed at once by a read of the same register, with the read's address phase overlapping the write's data phase, returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select from the system decoder |
| haddr | input | 32 | Transfer address; bits 7:2 are decoded |
| hwrite | input | 1 | 1 for write, 0 for read |
| htrans | input | 2 | Transfer type |
| hwdata | input | 32 | Write data, valid in the data phase |
| hreadyin | input | 1 | Bus ready; marks the end of the previous transfer |
| hrdata | output | 32 | Read data |
| hreadyout | output | 1 | Slave ready, always high |
| hresp | output | 2 | Transfer response, always OKAY |
| dco_coarse | output | 9 | Oscillator coarse control field |
| dco_fine | output | 23 | Oscillator fine control fields |
| dco_track | output | 1 | Oscillator mode: 1 phase tracking |
| det_div | output | DIV_W | Detector feedback divide value |
| det_track | output | 1 | Detector mode: 1 phase tracking |
| det_err | input | 16 | Signed error value from the converter |
| det_lead | input | 1 | 1 when the divided clock leads the reference |
| det_valid | input | 1 | Strobe that loads error and flag into the status word |

## Verification
Random transfers mix every htrans code with hsel and hreadyin taken high or low at random. This exposes any acceptance rule that looks at only some of the gating inputs. Offsets cover the writable registers, the read-only status word and unmapped holes, so a decode that aliases or wrongly accepts writes shows up as a mismatch in readback or side outputs. Directed cases check the coarse-field extraction with 0x8ff80000, a status capture with a negative error and the lead flag set, and a write immediately followed by a read of the same register. That last case separates a correct data-phase write from one that is one cycle late. Junk on hwdata during address phases exposes a write that samples its data in the wrong phase.

// File: rtl/dcoif_pkg.sv
package dcoif_pkg;

  // Word index = haddr[7:2]
  localparam int unsigned IDX_W     = 6;
  localparam logic [IDX_W-1:0] IDX_DIV   = 6'h00;  // 0x00
  localparam logic [IDX_W-1:0] IDX_DMODE = 6'h01;  // 0x04
  localparam logic [IDX_W-1:0] IDX_STAT  = 6'h02;  // 0x08
  localparam logic [IDX_W-1:0] IDX_OMODE = 6'h04;  // 0x10
  localparam logic [IDX_W-1:0] IDX_CW    = 6'h05;  // 0x14

  localparam int unsigned DATA_W = 32;

  // Control-word field split
  localparam int unsigned CW_COARSE_LSB = 19;
  localparam int unsigned CW_COARSE_W   = 9;
  localparam int unsigned CW_COARSE_MSB = CW_COARSE_LSB + CW_COARSE_W - 1;
  localparam int unsigned CW_FINE_W     = DATA_W - CW_COARSE_W;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/dcoif_addr_stage.sv
module dcoif_addr_stage
  import dcoif_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              ready_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [1:0]        trans_i,
  output logic              wr_q_o,
  output logic              rd_q_o,
  output logic [IDX_W-1:0]  idx_q_o
);

  logic             accept;
  logic             wr_d, rd_d;
  logic [IDX_W-1:0] idx_d;
  logic             wr_q, rd_q;
  logic [IDX_W-1:0] idx_q;

  // Only NONSEQ and SEQ carry data; trans_i[1] marks both
  always_comb begin
    accept = sel_i && ready_i && trans_i[1];
    wr_d   = accept && write_i;
    rd_d   = accept && !write_i;
    idx_d  = accept ? addr_i[IDX_W+1:2] : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      idx_q <= idx_d;
    end
  end

  assign wr_q_o  = wr_q;
  assign rd_q_o  = rd_q;
  assign idx_q_o = idx_q;

  // R2
  accept_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && ready_i && (trans_i == TR_NONSEQ || trans_i == TR_SEQ) && write_i) |=> wr_q);

  // R3
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_i || !ready_i || trans_i == TR_IDLE || trans_i == TR_BUSY) |=> (!wr_q && !rd_q));

  // R2
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_q, rd_q}));

endmodule

// File: rtl/dcoif_ctrl_regs.sv
module dcoif_ctrl_regs
  import dcoif_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cw_o,
  output logic              omode_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              dmode_o
);

  logic [DATA_W-1:0] cw_q, cw_d;
  logic              om_q, om_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              dm_q, dm_d;
  logic              en_cw, en_om, en_div, en_dm;

  always_comb begin
    en_cw  = wr_i && (idx_i == IDX_CW);
    en_om  = wr_i && (idx_i == IDX_OMODE);
    en_div = wr_i && (idx_i == IDX_DIV);
    en_dm  = wr_i && (idx_i == IDX_DMODE);
    cw_d   = en_cw  ? wdata_i             : cw_q;
    om_d   = en_om  ? wdata_i[0]          : om_q;
    div_d  = en_div ? wdata_i[DIV_W-1:0]  : div_q;
    dm_d   = en_dm  ? wdata_i[0]          : dm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q  <= '0;
      om_q  <= 1'b0;
      div_q <= '0;
      dm_q  <= 1'b0;
    end else begin
      cw_q  <= cw_d;
      om_q  <= om_d;
      div_q <= div_d;
      dm_q  <= dm_d;
    end
  end

  assign cw_o    = cw_q;
  assign omode_o = om_q;
  assign div_o   = div_q;
  assign dmode_o = dm_q;

  // R4
  cw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && idx_i == IDX_CW) |=> (cw_q == $past(wdata_i)));

  // R3
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(cw_q) && $stable(om_q) && $stable(div_q) && $stable(dm_q)));

  // R9
  ro_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && idx_i == IDX_STAT) |=> ($stable(cw_q) && $stable(div_q)));

endmodule

// File: rtl/dcoif_err_capture.sv
module dcoif_err_capture
  import dcoif_pkg::*;
#(
  parameter int unsigned ERR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              lead_i,
  output logic [DATA_W-1:0] stat_o
);

  localparam int unsigned PAD_W = DATA_W - 1 - ERR_W;

  logic [DATA_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = valid_i ? {lead_i, {PAD_W{1'b0}}, err_i} : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R8
  stat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (stat_q[DATA_W-1] == $past(lead_i) && stat_q[ERR_W-1:0] == $past(err_i)));

  // R8
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(stat_q));

endmodule

// File: rtl/dco_ahb_regif.sv
module dco_ahb_regif
  import dcoif_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned ERR_W  = 16
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              hwrite,
  input  logic [1:0]        htrans,
  input  logic [31:0]       hwdata,
  input  logic              hreadyin,
  output logic [31:0]       hrdata,
  output logic              hreadyout,
  output logic [1:0]        hresp,
  output logic [8:0]        dco_coarse,
  output logic [22:0]       dco_fine,
  output logic              dco_track,
  output logic [DIV_W-1:0]  det_div,
  output logic              det_track,
  input  logic [ERR_W-1:0]  det_err,
  input  logic              det_lead,
  input  logic              det_valid
);

  logic             wr_q, rd_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      cw;
  logic             om, dm;
  logic [DIV_W-1:0] div;
  logic [31:0]      stat;
  logic [31:0]      rd_sel;

  dcoif_addr_stage #(.ADDR_W(ADDR_W)) i_addr (
    .clk     (hclk),
    .rst_n   (hresetn),
    .sel_i   (hsel),
    .ready_i (hreadyin),
    .addr_i  (haddr),
    .write_i (hwrite),
    .trans_i (htrans),
    .wr_q_o  (wr_q),
    .rd_q_o  (rd_q),
    .idx_q_o (idx_q)
  );

  dcoif_ctrl_regs #(.DIV_W(DIV_W)) i_regs (
    .clk     (hclk),
    .rst_n   (hresetn),
    .wr_i    (wr_q),
    .idx_i   (idx_q),
    .wdata_i (hwdata),
    .cw_o    (cw),
    .omode_o (om),
    .div_o   (div),
    .dmode_o (dm)
  );

  dcoif_err_capture #(.ERR_W(ERR_W)) i_cap (
    .clk     (hclk),
    .rst_n   (hresetn),
    .valid_i (det_valid),
    .err_i   (det_err),
    .lead_i  (det_lead),
    .stat_o  (stat)
  );

  // Data-phase read mux, driven from the captured word index
  always_comb begin
    rd_sel = '0;
    case (idx_q)
      IDX_CW:    rd_sel = cw;
      IDX_OMODE: rd_sel = {31'b0, om};
      IDX_DIV:   rd_sel = {{(32-DIV_W){1'b0}}, div};
      IDX_DMODE: rd_sel = {31'b0, dm};
      IDX_STAT:  rd_sel = stat;
      default:   rd_sel = '0;
    endcase
  end

  assign hrdata     = rd_q ? rd_sel : '0;
  assign hreadyout  = 1'b1;
  assign hresp      = RESP_OKAY;
  assign dco_coarse = cw[CW_COARSE_MSB:CW_COARSE_LSB];
  assign dco_fine   = {cw[31:CW_COARSE_MSB+1], cw[CW_COARSE_LSB-1:0]};
  assign dco_track  = om;
  assign det_div    = div;
  assign det_track  = dm;

  // R1
  reset_clear_chk: assert property (@(posedge hclk)
    !hresetn |-> (dco_coarse == '0 && dco_fine == '0 && !dco_track && !det_track && det_div == '0));

  // R10
  idle_rdata_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    !(hsel && hreadyin && htrans[1] && !hwrite) |=> (hrdata == '0));

  // R11
  mode_follow_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (wr_q && idx_q == IDX_OMODE) |=> (dco_track == $past(hwdata[0])));

endmodule

// File: tb/test_dco_ahb_regif.sv
module test_dco_ahb_regif;

  localparam int DIV_W = 8;

  logic        hclk = 1'b0;
  logic        hresetn = 1'b0;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic        hwrite = 1'b0;
  logic [1:0]  htrans = 2'b00;
  logic [31:0] hwdata = '0;
  logic        hreadyin = 1'b1;
  logic [31:0] hrdata;
  logic        hreadyout;
  logic [1:0]  hresp;
  logic [8:0]  dco_coarse;
  logic [22:0] dco_fine;
  logic        dco_track;
  logic [DIV_W-1:0] det_div;
  logic        det_track;
  logic [15:0] det_err = '0;
  logic        det_lead = 1'b0;
  logic        det_valid = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] m_cw, m_stat;
  logic        m_om, m_dm;
  logic [DIV_W-1:0] m_div;

  dco_ahb_regif #(.DIV_W(DIV_W)) i_dco_ahb_regif (
    .hclk, .hresetn, .hsel, .haddr, .hwrite, .htrans, .hwdata, .hreadyin,
    .hrdata, .hreadyout, .hresp, .dco_coarse, .dco_fine, .dco_track,
    .det_div, .det_track, .det_err, .det_lead, .det_valid
  );

  always #5 hclk = ~hclk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [5:0] idx);
    case (idx)
      6'h05:   return m_cw;
      6'h04:   return {31'b0, m_om};
      6'h00:   return {{(32-DIV_W){1'b0}}, m_div};
      6'h01:   return {31'b0, m_dm};
      6'h02:   return m_stat;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [8:0] exp_coarse(input logic [31:0] w);
    return w[27:19];
  endfunction

  function automatic logic [22:0] exp_fine(input logic [31:0] w);
    return {w[31:28], w[18:0]};
  endfunction

  task automatic check_sides(input string req);
    chk(dco_coarse == exp_coarse(m_cw), {req, " coarse"}, {23'b0, dco_coarse}, {23'b0, exp_coarse(m_cw)});
    chk(dco_fine == exp_fine(m_cw), {req, " fine"}, {9'b0, dco_fine}, {9'b0, exp_fine(m_cw)});
    chk(dco_track == m_om, {req, " osc mode"}, {31'b0, dco_track}, {31'b0, m_om});
    chk(det_div == m_div, {req, " divide"}, {{(32-DIV_W){1'b0}}, det_div}, {{(32-DIV_W){1'b0}}, m_div});
    chk(det_track == m_dm, {req, " det mode"}, {31'b0, det_track}, {31'b0, m_dm});
  endtask

  task automatic model_write(input logic [5:0] idx, input logic [31:0] d);
    case (idx)
      6'h05: m_cw  = d;
      6'h04: m_om  = d[0];
      6'h00: m_div = d[DIV_W-1:0];
      6'h01: m_dm  = d[0];
      default: ;
    endcase
  endtask

  // One non-pipelined transfer; data-phase outputs sampled mid-cycle
  task automatic xfer(input logic [31:0] a, input bit wr, input logic [31:0] d,
                      input logic [1:0] tr, input bit sel, input bit rdy, input string req);
    bit acc;
    logic [31:0] exp;
    acc = sel && rdy && tr[1];
    @(negedge hclk);
    hsel = sel; haddr = a; hwrite = wr; htrans = tr; hreadyin = rdy;
    hwdata = $urandom;
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b00; hreadyin = 1'b1; hwdata = d;
    exp = (!wr && acc) ? model_read(a[7:2]) : 32'h0;
    chk(hrdata == exp, {req, " R10 rdata"}, hrdata, exp);
    chk(hreadyout == 1'b1 && hresp == 2'b00, "R10 ready/okay", {29'b0, hreadyout, hresp}, 32'h4);
    @(negedge hclk);
    hwdata = $urandom;
    if (wr && acc) model_write(a[7:2], d);
    check_sides(req);
  endtask

  task automatic det_pulse(input logic [15:0] e, input bit l);
    @(negedge hclk);
    det_valid = 1'b1; det_err = e; det_lead = l;
    @(negedge hclk);
    det_valid = 1'b0; det_err = $urandom; det_lead = $urandom;
    m_stat = {l, 15'b0, e};
  endtask

  initial begin
    repeat (200000) @(posedge hclk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed1));
    m_cw = '0; m_om = 0; m_dm = 0; m_div = '0; m_stat = '0;
    repeat (3) @(negedge hclk);
    // R1 reset state
    check_sides("R1");
    chk(hrdata == 32'h0, "R1 rdata", hrdata, 32'h0);
    hresetn = 1'b1;
    @(negedge hclk);

    // R4 directed: coarse field from 0x8ff80000
    xfer(32'h9500_0014, 1, 32'h8ff8_0000, 2'b10, 1, 1, "R4");
    chk(dco_coarse == 9'h1ff, "R4 coarse 1ff", {23'b0, dco_coarse}, 32'h1ff);
    // R5 fine field
    chk(dco_fine == 23'h400000, "R5 fine", {9'b0, dco_fine}, 32'h400000);
    xfer(32'h9500_0014, 0, 32'h0, 2'b10, 1, 1, "R4 readback");
    // R6 oscillator mode
    xfer(32'h9500_0010, 1, 32'hffff_fff1, 2'b11, 1, 1, "R6");
    xfer(32'h9500_0010, 0, 32'h0, 2'b10, 1, 1, "R6 readback");
    // R7 divide and detector mode
    xfer(32'h9500_0000, 1, 32'h0000_0123, 2'b10, 1, 1, "R7 div");
    xfer(32'h9500_0004, 1, 32'h0000_0001, 2'b10, 1, 1, "R7 dmode");
    xfer(32'h9500_0000, 0, 32'h0, 2'b10, 1, 1, "R7 div readback");
    // R8 status capture
    det_pulse(16'h8001, 1'b1);
    xfer(32'h9500_0008, 0, 32'h0, 2'b10, 1, 1, "R8 status");
    chk(m_stat == 32'h8000_8001, "R8 model", m_stat, 32'h8000_8001);
    // R9 read-only and unmapped writes
    xfer(32'h9500_0008, 1, 32'h1234_5678, 2'b10, 1, 1, "R9 ro write");
    xfer(32'h9500_0008, 0, 32'h0, 2'b10, 1, 1, "R9 status kept");
    xfer(32'h9500_000c, 1, 32'hdead_beef, 2'b10, 1, 1, "R9 hole write");
    xfer(32'h9500_000c, 0, 32'h0, 2'b10, 1, 1, "R9 hole read");
    // R3 idle, busy, deselected, not ready
    xfer(32'h9500_0014, 1, 32'h0000_0000, 2'b00, 1, 1, "R3 idle");
    xfer(32'h9500_0014, 1, 32'h0000_0000, 2'b01, 1, 1, "R3 busy");
    xfer(32'h9500_0014, 1, 32'h0000_0000, 2'b10, 0, 1, "R3 nosel");
    xfer(32'h9500_0014, 1, 32'h0000_0000, 2'b10, 1, 0, "R3 noready");
    xfer(32'h9500_0014, 0, 32'h0, 2'b10, 1, 1, "R3 cw kept");

    // R11 back-to-back write then read of control word
    @(negedge hclk);
    hsel = 1; haddr = 32'h9500_0014; hwrite = 1; htrans = 2'b10; hwdata = 32'h0;
    @(negedge hclk);
    hwdata = 32'h1357_9bdf; hwrite = 0; htrans = 2'b11;
    @(negedge hclk);
    hsel = 0; htrans = 2'b00; hwdata = 32'h0;
    m_cw = 32'h1357_9bdf;
    chk(hrdata == 32'h1357_9bdf, "R11 b2b", hrdata, 32'h1357_9bdf);
    check_sides("R11");

    // R2 random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0] idx;
      int pick;
      pick = $urandom_range(0, 7);
      case (pick)
        0: idx = 6'h00; 1: idx = 6'h01; 2: idx = 6'h02; 3: idx = 6'h03;
        4: idx = 6'h04; 5: idx = 6'h05; 6: idx = 6'h06; default: idx = 6'h0f;
      endcase
      if ($urandom_range(0, 5) == 0)
        det_pulse($urandom, $urandom_range(0, 1));
      r = $urandom;
      xfer({24'h950000, idx, 2'b00}, $urandom_range(0, 1), r,
           2'($urandom_range(0, 3)), $urandom_range(0, 4) != 0,
           $urandom_range(0, 4) != 0, "R2 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule